// File: doc/BRIEF.md
# Lockable Backlight PWM Generator

This block drives a panel backlight with a pulse-width modulated signal. A free-running counter sweeps one period. The output is high while the count is below an active duty threshold. Software programs the period, the number of valid period bits and a 16-bit active count through a small register port. An optional fractional mode spreads the sub-cycle part of the active count across periods.

Period and duty writes land in shadow registers. They reach the active registers only when the counter wraps, and only while the governing lock is released. The lock is either a lock bit local to this block or a global lock input, as a control bit selects. A pending status bit lets software see that a buffered update has not yet been applied. The block also emits a one-cycle strobe at each period start, so a downstream consumer can align to the period grid.

Top module: `bklt_pwm_top`

## Requirements
- R1: After reset the output is low, the control word (address 0) reads 0, the period word (address 1) reads the reset period `RST_PERIOD` with bit-count field 0, and the duty word (address 2) reads 0.
- R2: The period word holds the period value in bits 15:0 and a bit-count field in bits 19:16; a field of 0 means 16. Only the low bit-count bits of the period are used. A masked value of 0 gives a period of 2 to the power of bit-count cycles. `period_strobe` is high exactly in the first cycle of every period.
- R3: With fractional mode off, the high time per period is the active count shifted right by (16 - bit-count), so the low bits are ignored.
- R4: With fractional mode on (control bit 1), the integer part is as in R3. The low (16 - bit-count) bits, left-aligned to 16 bits, are added at each period end into a 16-bit accumulator that starts at zero when new values are applied; a carry adds one high cycle to the next period.
- R5: While the enable bit (control bit 0) is 0, the output stays low.
- R6: A write to the period or duty word sets the pending bit (control bit 4, read-only).
- R7: While the governing lock is set, the active period and duty do not change and the pending bit stays set.
- R8: When the lock is clear and pending is set, the buffered values are applied at the next counter wrap; pending reads 0 from the following cycle and the new values govern the next period.
- R9: When the own-lock select (control bit 3) is 1, the local lock bit (control bit 2) governs and `master_lock` is ignored; when it is 0, `master_lock` governs and the local lock bit is ignored.
- R10: An integer duty equal to or above the period length keeps the output high for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 period, 2 duty |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (duty and period words return the shadow values) |
| master_lock | input | 1 | Global lock, used when own-lock select is 0 |
| pwm_out | output | 1 | Backlight PWM output |
| period_strobe | output | 1 | High in the first cycle of each period |

## Verification
The duty path is tried with full 16-bit periods, short masked periods carrying garbage in the ignored upper bits, a zero masked period, and duties above the period. These cases tell apart correct masking, a correct integer shift and correct saturation. Random active counts with fractional mode off show that the low bits are dropped. The same counts with fractional mode on, followed period by period, show the carry pattern of the accumulator and its clearing when new values are applied. Lock runs hold a pending update for several periods, first under the local lock and then under the global input. Each run then releases the lock and confirms the new duty from the very next period, and that the lock not selected has no effect.

// File: rtl/bklt_pkg.sv
// Shared constants, register layout and helper functions for the backlight PWM.
// Assumes PWM_W is a power of two no wider than the 16-bit data field.
package bklt_pkg;

    localparam int PWM_W  = 16;
    localparam int BC_W   = $clog2(PWM_W);
    localparam int BITS_W = BC_W + 1;
    localparam int LEN_W  = PWM_W + 1;
    localparam int REG_AW = 2;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] A_CTRL   = 2'd0;
    localparam logic [REG_AW-1:0] A_PERIOD = 2'd1;
    localparam logic [REG_AW-1:0] A_DUTY   = 2'd2;

    localparam int CTL_EN   = 0;
    localparam int CTL_FRAC = 1;
    localparam int CTL_LOCK = 2;
    localparam int CTL_OWN  = 3;
    localparam int CTL_PEND = 4;
    localparam int BITCNT_LSB = PWM_W;

    typedef struct packed {
        logic [BC_W-1:0]  bitcnt;
        logic [PWM_W-1:0] period;
        logic [PWM_W-1:0] duty;
    } cfg_t;

    // Number of valid bits selected by the bit-count field (0 stands for PWM_W).
    function automatic logic [BITS_W-1:0] eff_bits(input logic [BC_W-1:0] f);
        return (f == '0) ? BITS_W'(PWM_W) : {1'b0, f};
    endfunction

    // Period length in cycles: masked period, or the full range when it masks to 0.
    function automatic logic [LEN_W-1:0] period_len(input logic [PWM_W-1:0] p,
                                                    input logic [BC_W-1:0]  f);
        logic [LEN_W-1:0] full;
        logic [LEN_W-1:0] masked;
        full   = LEN_W'(1) << eff_bits(f);
        masked = {1'b0, p} & (full - LEN_W'(1));
        return (masked == '0) ? full : masked;
    endfunction

    // Integer duty: the upper bit-count bits of the active count.
    function automatic logic [LEN_W-1:0] duty_int(input logic [PWM_W-1:0] d,
                                                  input logic [BC_W-1:0]  f);
        return LEN_W'(d >> (BITS_W'(PWM_W) - eff_bits(f)));
    endfunction

    // Fraction: the remaining low bits, left-aligned to PWM_W.
    function automatic logic [PWM_W-1:0] duty_frac(input logic [PWM_W-1:0] d,
                                                   input logic [BC_W-1:0]  f);
        return d << eff_bits(f);
    endfunction

endpackage

// File: rtl/bklt_regs.sv
// Register port, shadow and active copies, pending flag and lock selection.
// Transfer of shadow to active happens only on a counter wrap with the
// governing lock clear and an update pending. A write in the transfer cycle
// keeps pending set so the newer value is applied at the following wrap.
module bklt_regs
    import bklt_pkg::*;
#(
    parameter logic [PWM_W-1:0] RST_PERIOD = 16'd32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [REG_DW-1:0] wdata_i,
    output logic [REG_DW-1:0] rdata_o,
    input  logic              master_lock_i,
    input  logic              wrap_i,
    output cfg_t              act_o,
    output logic              en_o,
    output logic              frac_o,
    output logic              xfer_o
);

    logic en_q, frac_q, lock_q, own_q, pend_q;
    cfg_t shd_q, act_q;
    logic wr_ctrl, wr_per, wr_duty, wr_buf, eff_lock;
    logic unused_wbits;

    assign unused_wbits = ^wdata_i[REG_DW-1:BITCNT_LSB+BC_W];

    assign wr_ctrl  = we_i && (addr_i == A_CTRL);
    assign wr_per   = we_i && (addr_i == A_PERIOD);
    assign wr_duty  = we_i && (addr_i == A_DUTY);
    assign wr_buf   = wr_per || wr_duty;
    assign eff_lock = own_q ? lock_q : master_lock_i;
    assign xfer_o   = wrap_i && !eff_lock && pend_q;

    // Control bits: enable, fractional mode, local lock, own-lock select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            frac_q <= 1'b0;
            lock_q <= 1'b0;
            own_q  <= 1'b0;
        end else if (wr_ctrl) begin
            en_q   <= wdata_i[CTL_EN];
            frac_q <= wdata_i[CTL_FRAC];
            lock_q <= wdata_i[CTL_LOCK];
            own_q  <= wdata_i[CTL_OWN];
        end
    end

    // Shadow copy written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q.period <= RST_PERIOD;
            shd_q.bitcnt <= '0;
            shd_q.duty   <= '0;
        end else begin
            if (wr_per) begin
                shd_q.period <= wdata_i[PWM_W-1:0];
                shd_q.bitcnt <= wdata_i[BITCNT_LSB +: BC_W];
            end
            if (wr_duty) begin
                shd_q.duty <= wdata_i[PWM_W-1:0];
            end
        end
    end

    // Pending: set by a buffered write, cleared by a transfer (write wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wr_buf) begin
            pend_q <= 1'b1;
        end else if (xfer_o) begin
            pend_q <= 1'b0;
        end
    end

    // Active copy used by the counter and compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q.period <= RST_PERIOD;
            act_q.bitcnt <= '0;
            act_q.duty   <= '0;
        end else if (xfer_o) begin
            act_q <= shd_q;
        end
    end

    // Read mux: control with status, then the shadow words.
    always_comb begin
        case (addr_i)
            A_CTRL:   rdata_o = REG_DW'({pend_q, own_q, lock_q, frac_q, en_q});
            A_PERIOD: rdata_o = REG_DW'({shd_q.bitcnt, shd_q.period});
            A_DUTY:   rdata_o = REG_DW'(shd_q.duty);
            default:  rdata_o = '0;
        endcase
    end

    assign act_o  = act_q;
    assign en_o   = en_q;
    assign frac_o = frac_q;

    // R6: a buffered write leaves an update pending.
    a_r6_write_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wr_buf |=> pend_q);

    // R7: while the governing lock holds, active values do not move.
    a_r7_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        eff_lock |=> $stable(act_q));

    // R8: an unlocked wrap with pending and no new write clears pending.
    a_r8_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && !eff_lock && pend_q && !wr_buf) |=> !pend_q);

    // R9: with own-lock deselected, the global input alone blocks transfers.
    a_r9_master_governs: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_q && master_lock_i) |=> $stable(act_q));

endmodule

// File: rtl/bklt_counter.sv
// Period counter: counts 0 .. len-1 of the active period and wraps.
// Assumes the active period changes only on a wrap, so the count stays in range.
module bklt_counter
    import bklt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PWM_W-1:0] period_i,
    input  logic [BC_W-1:0]  bitcnt_i,
    output logic [PWM_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             start_o
);

    logic [PWM_W-1:0] cnt_q;
    logic [LEN_W-1:0] len;

    assign len     = period_len(period_i, bitcnt_i);
    assign wrap_o  = ({1'b0, cnt_q} == (len - LEN_W'(1)));
    assign start_o = (cnt_q == '0);
    assign cnt_o   = cnt_q;

    // Advance the count, returning to zero at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wrap_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PWM_W'(1);
        end
    end

    // R2: the count never reaches the period length.
    a_r2_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_q} < len));

endmodule

// File: rtl/bklt_duty.sv
// Duty threshold, fractional dither accumulator and output compare.
// Assumes wrap and transfer come from the counter and register modules in the
// same cycle; the accumulator restarts whenever new values are applied.
module bklt_duty
    import bklt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PWM_W-1:0] duty_i,
    input  logic [BC_W-1:0]  bitcnt_i,
    input  logic             en_i,
    input  logic             frac_en_i,
    input  logic             wrap_i,
    input  logic             xfer_i,
    input  logic [PWM_W-1:0] cnt_i,
    output logic             pwm_o
);

    logic [PWM_W-1:0] acc_q;
    logic             extra_q;
    logic [PWM_W-1:0] frac;
    logic [PWM_W:0]   sum;
    logic [LEN_W-1:0] thr;

    assign frac  = frac_en_i ? duty_frac(duty_i, bitcnt_i) : '0;
    assign sum   = {1'b0, acc_q} + {1'b0, frac};
    assign thr   = duty_int(duty_i, bitcnt_i) + LEN_W'(frac_en_i & extra_q);
    assign pwm_o = en_i && ({1'b0, cnt_i} < thr);

    // Dither accumulator: restart on transfer, else add the fraction at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            extra_q <= 1'b0;
        end else if (xfer_i) begin
            acc_q   <= '0;
            extra_q <= 1'b0;
        end else if (wrap_i) begin
            acc_q   <= sum[PWM_W-1:0];
            extra_q <= sum[PWM_W];
        end
    end

    // R4: the extra cycle decision changes only at a period boundary.
    a_r4_dither_steps_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(extra_q));

    // R4: applying new values restarts the accumulator from zero.
    a_r4_acc_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> (acc_q == '0 && !extra_q));

endmodule

// File: rtl/bklt_pwm_top.sv
// Lockable backlight PWM generator: registers, period counter and duty compare.
// Assumes a single clock domain for the register port and the PWM.
module bklt_pwm_top
    import bklt_pkg::*;
#(
    parameter logic [PWM_W-1:0] RST_PERIOD = 16'd32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              master_lock,
    output logic              pwm_out,
    output logic              period_strobe
);

    cfg_t             act;
    logic             en, frac_en, xfer, wrap;
    logic [PWM_W-1:0] cnt;

    bklt_regs #(.RST_PERIOD(RST_PERIOD)) i_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .we_i          (reg_we),
        .addr_i        (reg_addr),
        .wdata_i       (reg_wdata),
        .rdata_o       (reg_rdata),
        .master_lock_i (master_lock),
        .wrap_i        (wrap),
        .act_o         (act),
        .en_o          (en),
        .frac_o        (frac_en),
        .xfer_o        (xfer)
    );

    bklt_counter i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (act.period),
        .bitcnt_i (act.bitcnt),
        .cnt_o    (cnt),
        .wrap_o   (wrap),
        .start_o  (period_strobe)
    );

    bklt_duty i_duty (
        .clk       (clk),
        .rst_n     (rst_n),
        .duty_i    (act.duty),
        .bitcnt_i  (act.bitcnt),
        .en_i      (en),
        .frac_en_i (frac_en),
        .wrap_i    (wrap),
        .xfer_i    (xfer),
        .cnt_i     (cnt),
        .pwm_o     (pwm_out)
    );

endmodule

// File: tb/test_bklt_pwm_top.sv
`timescale 1ns/1ps
module test_bklt_pwm_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        master_lock = 1'b0;
    logic        pwm_out;
    logic        period_strobe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bklt_pwm_top #(.RST_PERIOD(16'd32)) i_bklt_pwm_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .master_lock(master_lock),
        .pwm_out(pwm_out), .period_strobe(period_strobe)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic set_master(input logic v);
        @(posedge clk); #1;
        master_lock = v;
    endtask

    // Leaves the bench at the first negedge after the transfer (a period start).
    task automatic wait_pend(input string tag);
        int n;
        bit seen;
        n = 0; seen = 1'b0;
        while (!seen && n < 5000) begin
            @(negedge clk);
            if (!reg_rdata[4]) seen = 1'b1;
            n++;
        end
        check_eq({tag, " pending clears"}, int'(seen), 1);
    endtask

    task automatic wait_strobe();
        @(negedge clk);
        while (!period_strobe) @(negedge clk);
    endtask

    // Expected high count per period from the integer duty and dither model.
    function automatic int exp_high(input int idut, input int ext, input int plen);
        return (idut + ext < plen) ? idut + ext : plen;
    endfunction

    task automatic measure(input int nper, input int idut, input int frac16,
                           input int plen, input string tag);
        int acc;
        int ext;
        acc = 0; ext = 0;
        for (int p = 0; p < nper; p++) begin
            int hi;
            hi = 0;
            check_eq("R2 strobe at period start", int'(period_strobe), 1);
            for (int i = 0; i < plen; i++) begin
                if (i > 0) @(negedge clk);
                hi += int'(pwm_out);
            end
            check_eq(tag, hi, exp_high(idut, ext, plen));
            acc = acc + frac16;
            ext = acc >> 16;
            acc = acc & 32'hFFFF;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd17);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check_eq("R1 out low", int'(pwm_out), 0);
        check_eq("R1 ctrl", int'(reg_rdata), 0);
        @(posedge clk); #1 reg_addr = 2'd1;
        @(negedge clk);
        check_eq("R1 period word", int'(reg_rdata), 32);
        @(posedge clk); #1 reg_addr = 2'd2;
        @(negedge clk);
        check_eq("R1 duty word", int'(reg_rdata), 0);
        @(posedge clk); #1 reg_addr = 2'd0;

        // R5: enable off, duty above period, output stays low
        wr(2'd0, 32'h8);
        wr(2'd2, 32'h8000);
        wait_pend("R5");
        measure(2, 0, 0, 32, "R5 disabled low");

        // R10: enabled, integer duty 32768 against period 32
        wr(2'd0, 32'h9);
        wait_strobe();
        measure(2, 32768, 0, 32, "R10 full high");

        // R2: bit-count field 0 means 16 bits, period 40, duty 5
        wr(2'd1, 32'h0000_0028);
        wr(2'd2, 32'h0000_0005);
        wait_pend("R2");
        measure(2, 5, 0, 40, "R2 16-bit period");

        // R3: bit-count 4, period garbage masked to 6, low duty bits ignored
        wr(2'd1, 32'h0004_FFF6);
        wr(2'd2, 32'h0000_3FFF);
        wait_pend("R3");
        measure(2, 3, 0, 6, "R3 integer duty");

        // R2: masked period 0 with bit-count 3 gives 8 cycles
        wr(2'd1, 32'h0003_0008);
        wr(2'd2, 32'h0000_6000);
        wait_pend("R2 zero");
        measure(2, 3, 0, 8, "R2 zero period full range");

        // R4: fractional, bit-count 4, period 10, int 3, fraction quarter
        wr(2'd0, 32'hB);
        wr(2'd1, 32'h0004_000A);
        wr(2'd2, 32'h0000_3400);
        wait_pend("R4");
        measure(8, 3, 16'h4000, 10, "R4 dither");

        // R7 / R8: local lock holds an update, release applies it
        wr(2'd0, 32'h9);
        wr(2'd2, 32'h0000_2000);
        wait_pend("R7 setup");
        wr(2'd0, 32'hD);
        wr(2'd2, 32'h0000_7000);
        @(negedge clk);
        check_eq("R6 pending set", int'(reg_rdata[4]), 1);
        wait_strobe();
        measure(3, 2, 0, 10, "R7 locked old duty");
        check_eq("R7 pending held", int'(reg_rdata[4]), 1);
        wr(2'd0, 32'h9);
        wait_pend("R8");
        measure(2, 7, 0, 10, "R8 applied after release");

        // R9: own-lock off, global input governs
        wr(2'd0, 32'h1);
        set_master(1'b1);
        wr(2'd2, 32'h0000_4000);
        wait_strobe();
        measure(3, 7, 0, 10, "R9 master lock holds");
        check_eq("R9 pending held", int'(reg_rdata[4]), 1);
        set_master(1'b0);
        wait_pend("R9 release");
        measure(2, 4, 0, 10, "R9 applied after master release");

        // R9: local lock bit ignored while own-lock is off
        wr(2'd0, 32'h5);
        wr(2'd2, 32'h0000_1000);
        wait_pend("R9 local ignored");
        measure(2, 1, 0, 10, "R9 local lock ignored");

        // R3: random integer-mode configurations
        for (int k = 0; k < 12; k++) begin
            int bits, mask, lo, per, duty;
            bits = 3 + int'($urandom % 6);
            mask = (1 << bits) - 1;
            lo   = 1 + int'($urandom % mask);
            per  = (int'($urandom & 32'hFFFF) & ~mask & 32'hFFFF) | lo;
            duty = int'($urandom & 32'hFFFF);
            wr(2'd0, 32'h9);
            wr(2'd1, 32'((bits << 16) | per));
            wr(2'd2, 32'(duty));
            wait_pend("R3 random");
            measure(2, duty >> (16 - bits), 0, lo, "R3 random duty");
        end

        // R4: random fractional configurations
        for (int k = 0; k < 6; k++) begin
            int bits, mask, lo, duty;
            bits = 3 + int'($urandom % 3);
            mask = (1 << bits) - 1;
            lo   = 1 + int'($urandom % mask);
            duty = int'($urandom & 32'hFFFF);
            wr(2'd0, 32'hB);
            wr(2'd1, 32'((bits << 16) | lo));
            wr(2'd2, 32'(duty));
            wait_pend("R4 random");
            measure(6, duty >> (16 - bits), (duty << bits) & 32'hFFFF, lo,
                    "R4 random dither");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule